// File: doc/BRIEF.md
# Symmetric Glitch-Rejecting Input Filter Bank

This block cleans up the logic-level command inputs of a power-stage gate driver. Those are the upper-switch commands, the lower-switch commands and the global enable. Each channel takes one asynchronous input bit and brings it into the clock domain through a chain of flip-flops. It then qualifies every level change with a counter. A new level reaches the filtered output only after it has been seen without interruption for `FILT_CYCLES` clock cycles. Any shorter excursion, high-going or low-going, is dropped completely. It is not passed on in shortened form.

Rising and falling changes go through the same synchronizer depth and the same qualification count. Every pulse that survives therefore leaves the block with the same width it had on entry, delayed by a fixed latency. At a 100 MHz clock, the default of 25 cycles gives a qualification window of 250 ns. A command must be held for at least twice that window to get through with margin when the clock tolerance is added in.

The block carries levels, not a stream of data words. Every port is a plain wire with no valid/ready handshake, and there is no back-pressure: an output simply follows its qualified input level. Channels are fully independent of one another.

Top module: `fglt_bank`

## Requirements
- R1: While `rst_n` is low every bit of `filt_out` is 0 (gate off), whatever `raw_in` does. `filt_out` stays 0 after reset is released until an input has been qualified as high.
- R2: On a channel whose output is 0, a high pulse on `raw_in` lasting fewer than `FILT_CYCLES` sampling clock cycles causes no change on that channel's `filt_out`.
- R3: On a channel whose output is 1, a low pulse on `raw_in` lasting fewer than `FILT_CYCLES` sampling clock cycles causes no change on that channel's `filt_out`.
- R4: A pulse of either polarity lasting `FILT_CYCLES` cycles or more appears on `filt_out` with exactly the same width in clock cycles.
- R5: A qualified input change reaches `filt_out` on the (`SYNC_STAGES` + `FILT_CYCLES`)-th rising clock edge that samples the new level. The latency is the same for rising and falling changes.
- R6: Activity on one channel never changes the `filt_out` bit of any other channel.
- R7: The qualification count restarts on every change of the synchronized input. A train of excursions, each shorter than `FILT_CYCLES` and separated by one-cycle returns to the old level, never toggles the output, however long the train runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NUM_CH | Asynchronous command inputs, one bit per channel |
| filt_out | output | NUM_CH | Qualified, synchronized command levels, one bit per channel |

## Verification
The main function is driven with single pulses of both polarities. Their widths are chosen to sit on either side of the qualification count: 1 cycle, several cycles, one cycle short of the count, exactly the count, one cycle over it, and well above it. This separates an off-by-one threshold from correct rejection. Surviving pulses are checked for width and for the latency of their first edge, which exposes any mismatch between the rising and falling paths. A bounce train with one-cycle returns shows whether the counter really restarts or only pauses. The untouched channels are watched throughout every pulse, and reset is applied both from power-up with the inputs held high and in the middle of operation.

// File: rtl/fglt_pkg.sv
package fglt_pkg;
  // Default shape: three upper, three lower and one enable channel.
  localparam int DEF_NUM_CH      = 7;
  // 250 ns at a 100 MHz sampling clock.
  localparam int DEF_FILT_CYCLES = 25;
  localparam int DEF_SYNC_STAGES = 2;

  // Width of a counter that must reach max_val.
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/fglt_sync.sv
module fglt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= 1'b0;
          else        chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fglt_qualifier.sv
module fglt_qualifier #(
  parameter int FILT_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_out
);
  import fglt_pkg::*;

  localparam int              CW   = cnt_width(FILT_CYCLES - 1);
  localparam logic [CW-1:0]   LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          held;

  // The counter runs only while the input disagrees with the held level.
  // Any return to agreement clears it, so every change starts over.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      run_cnt <= '0;
    end else if (level_in == held) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      held    <= level_in;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign level_out = held;
endmodule

// File: rtl/fglt_bank.sv
module fglt_bank #(
  parameter int NUM_CH      = fglt_pkg::DEF_NUM_CH,
  parameter int FILT_CYCLES = fglt_pkg::DEF_FILT_CYCLES,
  parameter int SYNC_STAGES = fglt_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] filt_out
);
  // Synchronized copy of each input, before qualification.
  logic [NUM_CH-1:0] sampled;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      fglt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in[c]),
        .q     (sampled[c])
      );
      fglt_qualifier #(.FILT_CYCLES(FILT_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (sampled[c]),
        .level_out (filt_out[c])
      );
    end
  endgenerate
endmodule

// File: rtl/fglt_bank_chk.sv
module fglt_bank_chk #(
  parameter int NUM_CH      = 7,
  parameter int FILT_CYCLES = 25,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] raw_in,
  input logic [NUM_CH-1:0] sampled,
  input logic [NUM_CH-1:0] filt_out
);
  import fglt_pkg::*;

  localparam int            SW   = cnt_width(FILT_CYCLES);
  localparam logic [SW-1:0] SAT  = SW'(FILT_CYCLES);
  localparam logic [SW-1:0] NEED = SW'(FILT_CYCLES - 1);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (filt_out == '0)); // R1

  AST_RESET_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sampled == '0)); // R1

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mon
      logic          prev;
      logic [SW-1:0] stable_cnt;

      // Counts, up to a cap, how long the synchronized input has kept its level.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev       <= 1'b0;
          stable_cnt <= '0;
        end else begin
          prev <= sampled[c];
          if (sampled[c] != prev)  stable_cnt <= '0;
          else if (stable_cnt != SAT) stable_cnt <= stable_cnt + 1'b1;
        end
      end

      AST_NO_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out[c]) |-> ((stable_cnt == NEED) && (filt_out[c] == prev))); // R2

      AST_STABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_cnt >= NEED) |-> (filt_out[c] == prev)); // R4
    end
  endgenerate

  logic unused_raw;
  assign unused_raw = ^raw_in;
endmodule

bind fglt_bank fglt_bank_chk #(
  .NUM_CH(NUM_CH), .FILT_CYCLES(FILT_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .sampled(sampled), .filt_out(filt_out)
);

// File: tb/sim_fglt_bank.sv
module sim_fglt_bank;
  localparam int NCH  = 7;
  localparam int FILT = 25;
  localparam int SYNC = 2;
  localparam int LAT  = FILT + SYNC;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] raw = '0;
  logic [NCH-1:0] fout;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fglt_bank #(.NUM_CH(NCH), .FILT_CYCLES(FILT), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw), .filt_out(fout)
  );

  // Row fields: channel [12:10], baseline level [9], width [8:1], survives [0].
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'd1,   1'b0},
    {3'd1, 1'b0, 8'd12,  1'b0},
    {3'd2, 1'b0, 8'd24,  1'b0},
    {3'd3, 1'b0, 8'd25,  1'b1},
    {3'd4, 1'b0, 8'd26,  1'b1},
    {3'd5, 1'b0, 8'd60,  1'b1},
    {3'd6, 1'b1, 8'd1,   1'b0},
    {3'd0, 1'b1, 8'd24,  1'b0},
    {3'd1, 1'b1, 8'd25,  1'b1},
    {3'd2, 1'b1, 8'd40,  1'b1},
    {3'd6, 1'b0, 8'd25,  1'b1},
    {3'd3, 1'b1, 8'd100, 1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_pulse(input int ch, input logic base, input int w, input logic pass);
    int first;
    int cnt;
    int other_bad;
    raw[ch] = base;
    settle(LAT + 4);
    check("R4", "baseline level", int'(fout[ch]), int'(base));
    first = -1; cnt = 0; other_bad = 0;
    raw[ch] = ~base;
    for (int i = 1; i <= w + LAT + 6; i++) begin
      @(negedge clk);
      if (fout[ch] != base) begin
        cnt++;
        if (first < 0) first = i;
      end
      if ((fout & ~(NCH'(1) << ch)) != '0) other_bad++;
      if (i == w) raw[ch] = base;
    end
    if (pass) begin
      check("R4", "output pulse width", cnt, w);
      check("R5", "edge latency", first, LAT);
    end else if (base == 1'b0) begin
      check("R2", "short high pulse leak", cnt, 0);
    end else begin
      check("R3", "short low pulse leak", cnt, 0);
    end
    check("R6", "other channels disturbed", other_bad, 0);
    raw[ch] = 1'b0;
    settle(LAT + 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seen;
    // R1: reset holds outputs low with all inputs high.
    raw = '1;
    settle(5);
    check("R1", "outputs in reset", int'(fout), 0);
    rst_n = 1'b1;
    settle(1);
    check("R1", "outputs just after release", int'(fout), 0);
    settle(LAT - 2);
    check("R5", "still low one cycle before latency", int'(fout), 0);
    settle(1);
    check("R5", "all high at latency from reset", int'(fout), (1 << NCH) - 1);
    raw = '0;
    settle(LAT + 4);
    check("R4", "all low again", int'(fout), 0);

    // Table of single pulses.
    for (int v = 0; v < NV; v++) begin
      run_pulse(int'(VEC[v][12:10]), VEC[v][9], int'(VEC[v][8:1]), VEC[v][0]);
    end

    // R7: bounce train with one-cycle returns never qualifies.
    seen = 0;
    for (int b = 0; b < 5; b++) begin
      raw[2] = 1'b1;
      for (int i = 0; i < FILT - 1; i++) begin
        @(negedge clk);
        if (fout[2]) seen++;
      end
      raw[2] = 1'b0;
      @(negedge clk);
      if (fout[2]) seen++;
    end
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      if (fout[2]) seen++;
    end
    check("R7", "bounce train output cycles high", seen, 0);

    // R1: reset in mid operation forces the gate off.
    raw[0] = 1'b1;
    settle(LAT + 4);
    check("R4", "channel 0 high before reset", int'(fout[0]), 1);
    rst_n = 1'b0;
    settle(1);
    check("R1", "mid-run reset clears outputs", int'(fout), 0);
    raw = '0;
    settle(2);
    rst_n = 1'b1;
    settle(LAT + 4);
    check("R1", "outputs low after mid-run reset", int'(fout), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule